// File: doc/BRIEF.md
# Bus Access Partition Checker

This block sits between the initiators of a shared on-chip bus (processor cores and hardware engines) and the shared memory and I/O targets behind it. Every transaction is checked before it reaches a target. The checker maps the address to one of a set of programmable regions. It then looks up a single allow bit for that pairing of initiator and region. An access that is allowed goes on to the target. An access that is refused never reaches the target, and the initiator gets an error response. The refusal is also recorded and an interrupt is raised, so that a supervisor can act on it. An address that falls in no region is always refused.

During boot, software uses a configuration port to set each region's inclusive base and limit and each region's initiator mask. It then seals the configuration. Once sealed, the regions and the table are frozen until reset. Any later attempt to change them has no effect, and a saturating counter records the attempt. The violation record holds the most recent offender's initiator ID, its address and its direction. Each initiator also has its own saturating violation counter.

A request finite-state machine runs each transaction through a fixed sequence:

- `RQ_IDLE` always moves to `RQ_LOOKUP` when `req_valid` is high.
- `RQ_LOOKUP` moves to `RQ_PASS` if the access is allowed, and to `RQ_BLOCK` if it is refused.
- Both `RQ_PASS` and `RQ_BLOCK` always move to `RQ_REPLY`.
- `RQ_REPLY` always moves back to `RQ_IDLE`.

A configuration finite-state machine has two states. It moves from `CF_OPEN` to `CF_SEALED` on a seal command. It leaves `CF_SEALED` only through reset.

Top module: `bus_fence`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response has been given. `rsp_valid` is high for exactly one cycle, the third cycle after the accepting edge. `req_ready` is high again in the cycle after that.
- R2: Region r matches an address when base_r <= address <= limit_r, with both bounds inclusive. If several regions match, the lowest index wins. After reset no region matches any address.
- R3: Bit i of region r's mask permits initiator i. An allowed access drives `tgt_valid` for one cycle, in the second cycle after acceptance. In that cycle the target signals carry the request's address, direction and write data; they are zero in every other cycle. An allowed read returns the `tgt_rdata` sampled in that cycle. An allowed write returns zero data. Either returns `rsp_err` = 0.
- R4: A refused access never asserts `tgt_valid`. This includes an address that matches no region. It returns `rsp_err` = 1 with `rsp_rdata` = 0.
- R5: The configuration command codes on `cfg_kind` are: 0 = set base of region `cfg_idx`, 1 = set limit, 2 = set mask (bit i of `cfg_wdata` is initiator i), 3 = seal, 4 = acknowledge. Seal sets `locked`, which only reset clears. While locked, commands 0, 1 and 2 change nothing.
- R6: Each command 0, 1 or 2 issued while locked increments `ign_cnt` by one. The count saturates at its maximum.
- R7: A refused access sets `irq` in the cycle its response is given. In that same cycle, `vio_id`, `vio_addr` and `vio_write` take the values of that access. The record always holds the latest refusal.
- R8: Initiator i's refusal count appears on `vio_cnts[i*VCNT_W +: VCNT_W]`. It increments on each of that initiator's refusals and saturates at 2^VCNT_W-1.
- R9: Command 4 clears `irq` and leaves the record intact. If a refusal is logged on the same edge, `irq` stays set.
- R10: After reset the outputs are as follows. `req_ready` = 1, `locked` = 0, `irq` = 0. The record, all counters, the response outputs and the target outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration command strobe |
| cfg_kind | input | 3 | Command code (see R5) |
| cfg_idx | input | RIDX_W | Region index |
| cfg_wdata | input | AW | Base, limit or initiator mask |
| req_valid | input | 1 | Initiator request present |
| req_ready | output | 1 | Checker can accept a request |
| req_id | input | ID_W | Initiator ID |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | DW | Read data (zero on write or refusal) |
| tgt_valid | output | 1 | Forwarded access strobe |
| tgt_write | output | 1 | Forwarded direction |
| tgt_addr | output | AW | Forwarded address |
| tgt_wdata | output | DW | Forwarded write data |
| tgt_rdata | input | DW | Target read data, sampled while `tgt_valid` is high |
| locked | output | 1 | Configuration sealed |
| ign_cnt | output | ICNT_W | Count of ignored commands after seal |
| irq | output | 1 | Violation interrupt |
| vio_id | output | ID_W | Initiator of the latest refusal |
| vio_addr | output | AW | Address of the latest refusal |
| vio_write | output | 1 | Direction of the latest refusal |
| vio_cnts | output | N_INIT*VCNT_W | Per-initiator refusal counters |

## Verification
Suppose a region bound or a mask bit holds the wrong value. That fault shows up on the third cycle after acceptance: `rsp_err` has the wrong value, and `tgt_valid` appeared (or failed to appear) one cycle earlier. Suppose instead the request state register strays. Then `req_ready`, `tgt_valid` or `rsp_valid` fall out of their fixed positions in the four-cycle pattern on the very next cycle. A fault in the seal, the ignored-command counter or the violation log shows up one edge after the offending command or refusal, on `locked`, `ign_cnt`, `irq`, the record or `vio_cnts`.

// File: rtl/bus_fence_pkg.sv
package bus_fence_pkg;

    typedef enum logic [2:0] {
        RQ_IDLE,
        RQ_LOOKUP,
        RQ_PASS,
        RQ_BLOCK,
        RQ_REPLY
    } rq_state_e;

    typedef enum logic {
        CF_OPEN,
        CF_SEALED
    } cf_state_e;

    localparam logic [2:0] K_BASE  = 3'd0;
    localparam logic [2:0] K_LIMIT = 3'd1;
    localparam logic [2:0] K_MASK  = 3'd2;
    localparam logic [2:0] K_SEAL  = 3'd3;
    localparam logic [2:0] K_ACK   = 3'd4;

endpackage

// File: rtl/bus_fence_regions.sv
module bus_fence_regions #(
    parameter int N_REG = 8,
    parameter int AW    = 32,
    localparam int RIDX_W = $clog2(N_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic              wr_limit,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [AW-1:0]     wr_data,
    input  logic [AW-1:0]     look_addr,
    output logic              hit,
    output logic [RIDX_W-1:0] hit_idx
);

    logic [AW-1:0]    base_q [N_REG];
    logic [AW-1:0]    lim_q  [N_REG];
    logic [N_REG-1:0] match;

    for (genvar g = 0; g < N_REG; g++) begin : g_region
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= '1;
                lim_q[g]  <= '0;
            end else begin
                if (wr_base && wr_idx == RIDX_W'(g))
                    base_q[g] <= wr_data;
                if (wr_limit && wr_idx == RIDX_W'(g))
                    lim_q[g] <= wr_data;
            end
        end
        assign match[g] = (base_q[g] <= look_addr) && (look_addr <= lim_q[g]);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int r = N_REG - 1; r >= 0; r--) begin
            if (match[r]) begin
                hit     = 1'b1;
                hit_idx = RIDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/bus_fence_perm.sv
module bus_fence_perm #(
    parameter int N_REG  = 8,
    parameter int N_INIT = 4,
    localparam int RIDX_W = $clog2(N_REG),
    localparam int ID_W   = $clog2(N_INIT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [N_INIT-1:0] wr_mask,
    input  logic              hit,
    input  logic [RIDX_W-1:0] rd_region,
    input  logic [ID_W-1:0]   rd_init,
    output logic              allow
);

    logic [N_INIT-1:0] mask_q [N_REG];

    for (genvar g = 0; g < N_REG; g++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask_q[g] <= '0;
            else if (wr_en && wr_idx == RIDX_W'(g))
                mask_q[g] <= wr_mask;
        end
    end

    assign allow = hit && mask_q[rd_region][rd_init];

endmodule

// File: rtl/bus_fence_log.sv
module bus_fence_log #(
    parameter int N_INIT = 4,
    parameter int AW     = 32,
    parameter int VCNT_W = 4,
    localparam int ID_W  = $clog2(N_INIT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     log_en,
    input  logic [ID_W-1:0]          log_id,
    input  logic [AW-1:0]            log_addr,
    input  logic                     log_wr,
    input  logic                     ack,
    output logic                     irq,
    output logic [ID_W-1:0]          vio_id,
    output logic [AW-1:0]            vio_addr,
    output logic                     vio_write,
    output logic [N_INIT*VCNT_W-1:0] vio_cnts
);

    logic [VCNT_W-1:0] cnt_q [N_INIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq       <= 1'b0;
            vio_id    <= '0;
            vio_addr  <= '0;
            vio_write <= 1'b0;
        end else if (log_en) begin
            irq       <= 1'b1;
            vio_id    <= log_id;
            vio_addr  <= log_addr;
            vio_write <= log_wr;
        end else if (ack) begin
            irq <= 1'b0;
        end
    end

    for (genvar g = 0; g < N_INIT; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q[g] <= '0;
            else if (log_en && log_id == ID_W'(g) && cnt_q[g] != '1)
                cnt_q[g] <= cnt_q[g] + 1'b1;
        end
        assign vio_cnts[g*VCNT_W +: VCNT_W] = cnt_q[g];
    end

endmodule

// File: rtl/bus_fence.sv
module bus_fence #(
    parameter int N_INIT = 4,
    parameter int N_REG  = 8,
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int VCNT_W = 4,
    parameter int ICNT_W = 4,
    localparam int ID_W   = $clog2(N_INIT),
    localparam int RIDX_W = $clog2(N_REG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_kind,
    input  logic [RIDX_W-1:0]        cfg_idx,
    input  logic [AW-1:0]            cfg_wdata,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ID_W-1:0]          req_id,
    input  logic [AW-1:0]            req_addr,
    input  logic                     req_write,
    input  logic [DW-1:0]            req_wdata,
    output logic                     rsp_valid,
    output logic                     rsp_err,
    output logic [DW-1:0]            rsp_rdata,
    output logic                     tgt_valid,
    output logic                     tgt_write,
    output logic [AW-1:0]            tgt_addr,
    output logic [DW-1:0]            tgt_wdata,
    input  logic [DW-1:0]            tgt_rdata,
    output logic                     locked,
    output logic [ICNT_W-1:0]        ign_cnt,
    output logic                     irq,
    output logic [ID_W-1:0]          vio_id,
    output logic [AW-1:0]            vio_addr,
    output logic                     vio_write,
    output logic [N_INIT*VCNT_W-1:0] vio_cnts
);

    import bus_fence_pkg::*;

    rq_state_e rq_q, rq_next;
    cf_state_e cf_q, cf_next;

    logic [ID_W-1:0]   cap_id;
    logic [AW-1:0]     cap_addr;
    logic              cap_wr;
    logic [DW-1:0]     cap_wdata;
    logic              allow_q;
    logic [DW-1:0]     data_q;

    logic              open_cfg;
    logic              wr_base, wr_limit, wr_mask;
    logic              table_cmd, ignored, seal_cmd, ack_cmd;
    logic              hit, allow, log_en;
    logic [RIDX_W-1:0] hit_idx;

    // ---------------- configuration decode ----------------
    assign open_cfg  = (cf_q == CF_OPEN);
    assign table_cmd = cfg_we && (cfg_kind == K_BASE || cfg_kind == K_LIMIT ||
                                  cfg_kind == K_MASK);
    assign wr_base   = cfg_we && cfg_kind == K_BASE  && open_cfg;
    assign wr_limit  = cfg_we && cfg_kind == K_LIMIT && open_cfg;
    assign wr_mask   = cfg_we && cfg_kind == K_MASK  && open_cfg;
    assign ignored   = table_cmd && !open_cfg;
    assign seal_cmd  = cfg_we && cfg_kind == K_SEAL;
    assign ack_cmd   = cfg_we && cfg_kind == K_ACK;
    assign locked    = (cf_q == CF_SEALED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cf_q <= CF_OPEN;
        else        cf_q <= cf_next;
    end

    always_comb begin
        cf_next = cf_q;
        unique case (cf_q)
            CF_OPEN:   if (seal_cmd) cf_next = CF_SEALED;
            CF_SEALED: cf_next = CF_SEALED;
            default:   cf_next = CF_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ign_cnt <= '0;
        else if (ignored && ign_cnt != '1)
            ign_cnt <= ign_cnt + 1'b1;
    end

    // ---------------- lookup path ----------------
    bus_fence_regions #(.N_REG(N_REG), .AW(AW)) u_regions (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_base   (wr_base),
        .wr_limit  (wr_limit),
        .wr_idx    (cfg_idx),
        .wr_data   (cfg_wdata),
        .look_addr (cap_addr),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    bus_fence_perm #(.N_REG(N_REG), .N_INIT(N_INIT)) u_perm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_mask),
        .wr_idx    (cfg_idx),
        .wr_mask   (cfg_wdata[N_INIT-1:0]),
        .hit       (hit),
        .rd_region (hit_idx),
        .rd_init   (cap_id),
        .allow     (allow)
    );

    bus_fence_log #(.N_INIT(N_INIT), .AW(AW), .VCNT_W(VCNT_W)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .log_en    (log_en),
        .log_id    (cap_id),
        .log_addr  (cap_addr),
        .log_wr    (cap_wr),
        .ack       (ack_cmd),
        .irq       (irq),
        .vio_id    (vio_id),
        .vio_addr  (vio_addr),
        .vio_write (vio_write),
        .vio_cnts  (vio_cnts)
    );

    // ---------------- request state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq_q <= RQ_IDLE;
        else        rq_q <= rq_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_id    <= '0;
            cap_addr  <= '0;
            cap_wr    <= 1'b0;
            cap_wdata <= '0;
            allow_q   <= 1'b0;
            data_q    <= '0;
        end else begin
            if (rq_q == RQ_IDLE && req_valid) begin
                cap_id    <= req_id;
                cap_addr  <= req_addr;
                cap_wr    <= req_write;
                cap_wdata <= req_wdata;
            end
            if (rq_q == RQ_LOOKUP)
                allow_q <= allow;
            if (rq_q == RQ_PASS)
                data_q <= cap_wr ? '0 : tgt_rdata;
            if (rq_q == RQ_BLOCK)
                data_q <= '0;
        end
    end

    always_comb begin
        rq_next   = rq_q;
        req_ready = 1'b0;
        tgt_valid = 1'b0;
        tgt_write = 1'b0;
        tgt_addr  = '0;
        tgt_wdata = '0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        log_en    = 1'b0;
        unique case (rq_q)
            RQ_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) rq_next = RQ_LOOKUP;
            end
            RQ_LOOKUP: begin
                rq_next = allow ? RQ_PASS : RQ_BLOCK;
            end
            RQ_PASS: begin
                tgt_valid = 1'b1;
                tgt_write = cap_wr;
                tgt_addr  = cap_addr;
                tgt_wdata = cap_wdata;
                rq_next   = RQ_REPLY;
            end
            RQ_BLOCK: begin
                log_en  = 1'b1;
                rq_next = RQ_REPLY;
            end
            RQ_REPLY: begin
                rsp_valid = 1'b1;
                rsp_err   = !allow_q;
                rsp_rdata = data_q;
                rq_next   = RQ_IDLE;
            end
            default: rq_next = RQ_IDLE;
        endcase
    end

endmodule

// File: rtl/bus_fence_chk.sv
module bus_fence_chk #(
    parameter int DW     = 32,
    parameter int ICNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DW-1:0]     rsp_rdata,
    input logic              tgt_valid,
    input logic              locked,
    input logic [ICNT_W-1:0] ign_cnt,
    input logic              irq
);

    // R1: response lands on the third cycle after acceptance
    p_rsp_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##2 rsp_valid);

    // R1: no new acceptance while a transaction is in flight
    p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: a forwarded access always completes without error
    p_fwd_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |=> (rsp_valid && !rsp_err));

    // R4: refused responses carry zero data
    p_block_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R5: seal is sticky until reset
    p_seal_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R6: ignored-command count never goes down
    p_ign_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ign_cnt >= $past(ign_cnt)));

    // R7: a refusal response always sees the interrupt raised
    p_irq_on_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> irq);

endmodule

bind bus_fence bus_fence_chk #(.DW(DW), .ICNT_W(ICNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .tgt_valid (tgt_valid),
    .locked    (locked),
    .ign_cnt   (ign_cnt),
    .irq       (irq)
);

// File: tb/bus_fence_test.sv
module bus_fence_test;

    localparam int N_INIT = 4, N_REG = 8, AW = 32, DW = 32, VCNT_W = 4, ICNT_W = 4;
    localparam int ID_W = 2, RIDX_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_kind = '0;
    logic [RIDX_W-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err, tgt_valid, tgt_write, locked, irq, vio_write;
    logic [DW-1:0] rsp_rdata, tgt_wdata, tgt_rdata;
    logic [AW-1:0] tgt_addr, vio_addr;
    logic [ICNT_W-1:0] ign_cnt;
    logic [ID_W-1:0] vio_id;
    logic [N_INIT*VCNT_W-1:0] vio_cnts;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    assign tgt_rdata = memf(tgt_addr);

    bus_fence #(.N_INIT(N_INIT), .N_REG(N_REG), .AW(AW), .DW(DW),
                .VCNT_W(VCNT_W), .ICNT_W(ICNT_W)) uut (.*);

    // ---------------- behavioural reference model ----------------
    int unsigned mb [8], ml [8];
    int unsigned mp [8];
    int m_ph, m_id, m_cnt [4], m_ign, m_vid;
    int unsigned m_addr, m_wd, m_rd, m_vaddr;
    bit m_wr, m_allow, m_lock, m_irq, m_vwr;

    function automatic bit decide(input int id, input int unsigned a);
        for (int r = 0; r < 8; r++)
            if (mb[r] <= a && a <= ml[r]) return mp[r][id];
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < 8; r++) begin mb[r] <= 32'hFFFF_FFFF; ml[r] <= 0; mp[r] <= 0; end
            for (int i = 0; i < 4; i++) m_cnt[i] <= 0;
            m_ph <= 0; m_id <= 0; m_addr <= 0; m_wd <= 0; m_rd <= 0; m_wr <= 0;
            m_allow <= 0; m_lock <= 0; m_irq <= 0; m_vid <= 0; m_vaddr <= 0; m_vwr <= 0;
            m_ign <= 0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                       m_id <= int'(req_id); m_addr <= req_addr; m_wr <= req_write;
                       m_wd <= req_wdata; m_ph <= 1;
                   end
                1: begin m_allow <= decide(m_id, m_addr); m_ph <= 2; end
                2: begin
                       if (m_allow) m_rd <= m_wr ? 0 : memf(m_addr);
                       else begin
                           m_rd <= 0; m_vid <= m_id; m_vaddr <= m_addr; m_vwr <= m_wr;
                           if (m_cnt[m_id] < 15) m_cnt[m_id] <= m_cnt[m_id] + 1;
                       end
                       m_ph <= 3;
                   end
                default: m_ph <= 0;
            endcase
            if (m_ph == 2 && !m_allow) m_irq <= 1;
            else if (cfg_we && cfg_kind == 4) m_irq <= 0;
            if (cfg_we) begin
                if (cfg_kind <= 2 && m_lock) begin
                    if (m_ign < 15) m_ign <= m_ign + 1;
                end else if (cfg_kind == 0) mb[cfg_idx] <= cfg_wdata;
                else if (cfg_kind == 1) ml[cfg_idx] <= cfg_wdata;
                else if (cfg_kind == 2) mp[cfg_idx] <= cfg_wdata & 32'hF;
                else if (cfg_kind == 3) m_lock <= 1;
            end
        end
    end

    task automatic cmp(input string tag, input string nm, input logic [31:0] a, input logic [31:0] e);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, nm, a, e, $time);
        end
    endtask

    // compare on every clock
    always @(negedge clk) if (rst_n) begin
        bit tv;
        tv = (m_ph == 2) && m_allow;
        cmp("R1", "req_ready", 32'(req_ready), 32'(m_ph == 0));
        cmp("R1", "rsp_valid", 32'(rsp_valid), 32'(m_ph == 3));
        cmp("R3", "tgt_valid", 32'(tgt_valid), 32'(tv));
        cmp("R3", "tgt_addr",  tgt_addr, tv ? m_addr : 0);
        cmp("R3", "tgt_write", 32'(tgt_write), 32'(tv && m_wr));
        cmp("R3", "tgt_wdata", tgt_wdata, tv ? m_wd : 0);
        cmp("R4", "rsp_err",   32'(rsp_err), 32'(m_ph == 3 && !m_allow));
        cmp("R3", "rsp_rdata", rsp_rdata, (m_ph == 3) ? m_rd : 0);
        cmp("R5", "locked",    32'(locked), 32'(m_lock));
        cmp("R6", "ign_cnt",   32'(ign_cnt), 32'(m_ign));
        cmp("R7", "irq",       32'(irq), 32'(m_irq));
        cmp("R7", "vio_id",    32'(vio_id), 32'(m_vid));
        cmp("R7", "vio_addr",  vio_addr, m_vaddr);
        cmp("R7", "vio_write", 32'(vio_write), 32'(m_vwr));
        for (int i = 0; i < 4; i++)
            cmp("R8", "vio_cnts", 32'(vio_cnts[i*4 +: 4]), 32'(m_cnt[i]));
    end

    // ---------------- stimulus ----------------
    task automatic cfg(input int kind, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_idx = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input int id, input logic [31:0] a, input bit wr, input bit ack_mid,
                          output bit err, output logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_id = 2'(id); req_addr = a; req_write = wr; req_wdata = a ^ 32'h5A5A_5A5A;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        if (ack_mid) begin cfg_we = 1'b1; cfg_kind = 3'd4; end
        @(negedge clk);
        cfg_we = 1'b0;
        err = rsp_err; d = rsp_rdata;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_bad++;
            $display("FAIL R1 watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit e;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        cmp("R10", "req_ready", 32'(req_ready), 1);
        cmp("R10", "irq", 32'(irq), 0);
        cmp("R10", "locked", 32'(locked), 0);
        cmp("R10", "vio_cnts", 32'(vio_cnts), 0);
        cmp("R10", "rsp_valid", 32'(rsp_valid), 0);

        cfg(0, 0, 32'h1000); cfg(1, 0, 32'h1FFF); cfg(2, 0, 32'h1);
        cfg(0, 1, 32'h2000); cfg(1, 1, 32'h2FFF); cfg(2, 1, 32'h2);
        cfg(0, 2, 32'h1800); cfg(1, 2, 32'h27FF); cfg(2, 2, 32'hF);
        cfg(0, 3, 32'h8000); cfg(1, 3, 32'h8000); cfg(2, 3, 32'hC);

        access(0, 32'h1004, 0, 0, e, d);
        cmp("R3", "allowed read err", 32'(e), 0);
        cmp("R3", "allowed read data", d, 32'h1004_EFFB);
        access(1, 32'h1004, 0, 0, e, d);
        cmp("R4", "refused read err", 32'(e), 1);
        cmp("R4", "refused read data", d, 0);
        cmp("R7", "irq after refusal", 32'(irq), 1);
        access(1, 32'h2010, 1, 0, e, d);
        cmp("R3", "allowed write err", 32'(e), 0);
        access(0, 32'h2010, 1, 0, e, d);
        cmp("R4", "refused write err", 32'(e), 1);
        cmp("R7", "vio_write", 32'(vio_write), 1);
        access(2, 32'h1800, 0, 0, e, d);
        cmp("R2", "overlap lowest wins", 32'(e), 1);
        access(0, 32'h1FFF, 0, 0, e, d);
        cmp("R2", "inclusive limit", 32'(e), 0);
        cmp("R2", "limit data", d, 32'h1FFF_E000);
        access(3, 32'h8000, 0, 0, e, d);
        cmp("R2", "single-address region", 32'(e), 0);
        access(3, 32'h8001, 0, 0, e, d);
        cmp("R2", "past limit", 32'(e), 1);
        access(0, 32'h0, 0, 0, e, d);
        cmp("R4", "no region match", 32'(e), 1);

        cfg(4, 0, 0);
        cmp("R9", "ack clears irq", 32'(irq), 0);
        cmp("R9", "record kept", vio_addr, 32'h0);

        cfg(3, 0, 0);
        cmp("R5", "sealed", 32'(locked), 1);
        cfg(2, 1, 32'hF);
        cmp("R6", "ignored count", 32'(ign_cnt), 1);
        access(0, 32'h2010, 1, 0, e, d);
        cmp("R5", "mask frozen", 32'(e), 1);
        cfg(0, 0, 32'h0);
        access(0, 32'h1004, 0, 0, e, d);
        cmp("R5", "base frozen", 32'(e), 0);

        for (int k = 0; k < 16; k++) access(1, 32'h0, 0, 0, e, d);
        cmp("R8", "saturated id1", 32'(vio_cnts[7:4]), 15);
        cmp("R8", "id0 count", 32'(vio_cnts[3:0]), 3);
        cmp("R8", "id2 count", 32'(vio_cnts[11:8]), 1);

        cfg(4, 0, 0);
        access(2, 32'h0, 0, 1, e, d);
        cmp("R9", "refusal beats ack", 32'(irq), 1);

        for (int k = 0; k < 20; k++) cfg(1, 2, 32'h0);
        cmp("R6", "ign saturates", 32'(ign_cnt), 15);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        cmp("R5", "reset unseals", 32'(locked), 0);
        cmp("R10", "counters cleared", 32'(vio_cnts), 0);
        cmp("R10", "ign cleared", 32'(ign_cnt), 0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule